// File: doc/BRIEF.md
# Flash Query and Identifier Read Responder

This block supplies the read word a parallel flash bank returns while it sits in parameter-query mode or identifier mode. The bank is one or more identical devices placed side by side on the data bus. Each device may run narrower than its native width. The block takes a byte offset, an access width and three geometry settings: bank width, device width and the device's native maximum width. From these it scales the offset into a table index, looks up a fixed parameter table or one of two 16-bit identifier codes, and forms the response of a single device. It then copies that response onto every device lane of the bank.

Several bank-width lanes are joined into one word when the access is wider than the bank. The parameter table is computed at build time from the sector size and the sector count. The command sequencer that selects the mode and the array storage sit outside this block. The response is formed combinationally and captured once into the read-data register when a read strobe arrives.

Top module: `cfi_query_responder`

## Requirements
- R1: While reset is asserted, and afterwards until the first read, `rdData` is zero and `rdValid` is low.
- R2: A read captured on a clock edge with `rdEn` high appears on `rdData`, with `rdValid` high, after that same edge. On cycles without `rdEn`, `rdValid` is low and `rdData` keeps its previous value.
- R3: All width settings are log2 of a byte count (0 = 1 byte, 1 = 2, 2 = 4). The index of the lane at byte address A is A shifted right by bankLog + maxLog - devLog.
- R4: A query index above 0x52 reads zero. High index bits never wrap into the table.
- R5: Query-table text entries: index 0x10..0x12 hold 0x51 0x52 0x59, 0x13 holds 0x01, 0x15 holds 0x31, 0x31..0x35 hold 0x50 0x52 0x49 0x31 0x30. Every index not named in R5 or R6 reads zero.
- R6: Geometry entries, where D = bankLog - devLog is log2 of the device count: 0x27 = SECTOR_LOG + BLOCK_LOG - D. 0x2A = 0x08 for a 1-byte bank and 0x0B otherwise. 0x2C = 0x01. 0x2D and 0x2E hold the low and high byte of (2^BLOCK_LOG >> D) - 1. 0x2F and 0x30 hold bits 15:8 and 23:16 of 2^SECTOR_LOG.
- R7: When devLog differs from maxLog (a wide part in byte mode), the table byte fills every byte of the device response instead of being zero-padded.
- R8: The read word is zero for any unsupported setting: any width setting above 2, devLog above bankLog or above maxLog, or devLog different from maxLog with devLog not 0.
- R9: Each device's response (table byte in its lowest byte and zero above when devLog equals maxLog; identifier code truncated to the device width) is repeated into every device-width slice of a lane.
- R10: When the access is wider than the bank, lane k occupies bytes k*bank..k*bank+bank-1 of the word and answers for byte address offset + k*bank.
- R11: Bytes of `rdData` at or above the access width are zero. An access narrower than the bank returns only the low bytes of lane 0.
- R12: With `idMode` = 1, the low 8 bits of the lane index select the response: 0 gives MANUF_CODE, 1 gives DEVICE_CODE, any other value gives zero. With `idMode` = 0 the query table answers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rdEn | input | 1 | Read strobe; captures a response this cycle |
| idMode | input | 1 | 1 = identifier mode, 0 = query mode |
| offset | input | ADDR_W | Byte offset of the access |
| accLog | input | LOG_W | log2 of the access width in bytes |
| bankLog | input | LOG_W | log2 of the bank width in bytes |
| devLog | input | LOG_W | log2 of the device width in use |
| maxLog | input | LOG_W | log2 of the device native maximum width |
| rdData | output | 8*DATA_BYTES | Registered read word |
| rdValid | output | 1 | High the cycle after a captured read |

## Verification
The bench builds the block with its default parameters: a 16-bit offset, a 4-byte word, 128 KiB sectors, 64 sectors and identifier codes 0x0089 and 0x0018. With a 4-byte word, every legal mix of bank width, device width and native width can be reached, including two- and four-device banks, byte-mode wide parts and two- or four-lane accesses over a one- or two-byte bank. The 16-bit offset lets indices well beyond 0x52 alias the text entries if the high bits were dropped. A 128 KiB sector gives a non-zero upper sector byte, and 64 sectors make the block-count entry move with the device count.

// File: rtl/cfi_qry_pkg.sv
package cfi_qry_pkg;

  // Control-to-datapath strobes for one read
  typedef struct packed {
    logic load;    // capture a new response on this edge
    logic idMode;  // identifier codes instead of the parameter table
    logic geomOk;  // geometry settings form a supported combination
    logic wideX8;  // part runs narrower than its native width
  } qryStrobe_t;

  // Highest table index that is still looked up
  localparam int unsigned TABLE_LAST = 32'h52;

endpackage

// File: rtl/cfi_qry_ctrl.sv
module cfi_qry_ctrl
  import cfi_qry_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int LANES   = 4,
  parameter int IDX_W   = 21,
  parameter int LOG_W   = 2,
  parameter int MAX_LOG = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rdEn,
  input  logic                        idMode,
  input  logic [ADDR_W-1:0]           offset,
  input  logic [LOG_W-1:0]            accLog,
  input  logic [LOG_W-1:0]            bankLog,
  input  logic [LOG_W-1:0]            devLog,
  input  logic [LOG_W-1:0]            maxLog,
  output qryStrobe_t                  strobe,
  output logic [LANES-1:0][IDX_W-1:0] laneIdx
);

  localparam int SH_W = LOG_W + 2;
  localparam logic [LOG_W-1:0] LOG_LIMIT = LOG_W'(MAX_LOG);

  logic [SH_W-1:0] shiftAmt;
  logic            widthsOk;
  logic            orderOk;
  logic            narrowOk;

  // R3: scale shift that maps a byte address onto a table index
  assign shiftAmt = SH_W'(bankLog) + SH_W'(maxLog) - SH_W'(devLog);

  // R8: legal geometry check
  assign widthsOk = (accLog <= LOG_LIMIT) && (bankLog <= LOG_LIMIT) && (maxLog <= LOG_LIMIT);
  assign orderOk  = (devLog <= bankLog) && (devLog <= maxLog);
  assign narrowOk = (devLog == maxLog) || (devLog == '0);

  always_comb begin
    strobe.load   = rdEn;
    strobe.idMode = idMode;
    strobe.geomOk = widthsOk && orderOk && narrowOk;
    strobe.wideX8 = (devLog != maxLog);
  end

  // R10: lane k answers for offset + k * bank width
  for (genvar k = 0; k < LANES; k++) begin : g_idx
    logic [IDX_W-1:0] laneAddr;
    assign laneAddr   = IDX_W'(offset) + (IDX_W'(k) << bankLog);
    assign laneIdx[k] = laneAddr >> shiftAmt;

    if (k > 0) begin : g_order
      // R10
      lane_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        laneIdx[k] >= laneIdx[k-1]);
    end
  end

endmodule

// File: rtl/cfi_qry_datapath.sv
module cfi_qry_datapath
  import cfi_qry_pkg::*;
#(
  parameter int          DATA_BYTES  = 4,
  parameter int          IDX_W       = 21,
  parameter int          LOG_W       = 2,
  parameter int          SECTOR_LOG  = 17,
  parameter int          BLOCK_LOG   = 6,
  parameter logic [15:0] MANUF_CODE  = 16'h0089,
  parameter logic [15:0] DEVICE_CODE = 16'h0018
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  qryStrobe_t                       strobe,
  input  logic [DATA_BYTES-1:0][IDX_W-1:0] laneIdx,
  input  logic [LOG_W-1:0]                 accLog,
  input  logic [LOG_W-1:0]                 bankLog,
  input  logic [LOG_W-1:0]                 devLog,
  output logic [8*DATA_BYTES-1:0]          rdData,
  output logic                             rdValid
);

  localparam int DATA_W = 8 * DATA_BYTES;
  localparam int SEL_W  = $clog2(DATA_BYTES);
  localparam int BLOCKS = 1 << BLOCK_LOG;
  localparam logic [63:0] SECTOR_BYTES = 64'(1) << SECTOR_LOG;
  localparam logic [7:0]  SEC_MID  = SECTOR_BYTES[15:8];
  localparam logic [7:0]  SEC_HIGH = SECTOR_BYTES[23:16];
  localparam logic [7:0]  SIZE_SUM = 8'(SECTOR_LOG + BLOCK_LOG);

  logic [LOG_W-1:0] devCntLog;
  logic [SEL_W-1:0] devMask;
  logic [SEL_W-1:0] bankMask;
  logic [SEL_W:0]   accBytes;
  logic [DATA_BYTES-1:0][DATA_BYTES-1:0][7:0] laneByte;
  logic [DATA_W-1:0] nextData;

  assign devCntLog = bankLog - devLog;
  assign devMask   = SEL_W'((1 << devLog) - 1);
  assign bankMask  = SEL_W'((1 << bankLog) - 1);
  assign accBytes  = (SEL_W+1)'(1) << accLog;

  // R5, R6: fixed parameter table, geometry entries derived from parameters
  function automatic logic [7:0] tableByte(input logic [7:0] idx,
                                           input logic [LOG_W-1:0] bLog,
                                           input logic [LOG_W-1:0] cntLog);
    logic [15:0] blocksM1;
    blocksM1 = 16'((BLOCKS >> cntLog) - 1);
    case (idx)
      8'h10: return 8'h51;
      8'h11: return 8'h52;
      8'h12: return 8'h59;
      8'h13: return 8'h01;
      8'h15: return 8'h31;
      8'h27: return SIZE_SUM - 8'(cntLog);
      8'h2A: return (bLog == '0) ? 8'h08 : 8'h0B;
      8'h2C: return 8'h01;
      8'h2D: return blocksM1[7:0];
      8'h2E: return blocksM1[15:8];
      8'h2F: return SEC_MID;
      8'h30: return SEC_HIGH;
      8'h31: return 8'h50;
      8'h32: return 8'h52;
      8'h33: return 8'h49;
      8'h34: return 8'h31;
      8'h35: return 8'h30;
      default: return 8'h00;
    endcase
  endfunction

  // One device-lane response per bank-width lane
  for (genvar k = 0; k < DATA_BYTES; k++) begin : g_lane
    logic        inRange;
    logic [7:0]  tblVal;
    logic [15:0] idCode;
    logic [SEL_W-1:0] slot;

    always_comb begin
      // R4: out-of-range index reads zero, no wrap of high bits
      inRange = (laneIdx[k] <= IDX_W'(TABLE_LAST));
      tblVal  = inRange ? tableByte(laneIdx[k][7:0], bankLog, devCntLog) : 8'h00;
      // R12: identifier select on the low index byte
      case (laneIdx[k][7:0])
        8'h00:   idCode = MANUF_CODE;
        8'h01:   idCode = DEVICE_CODE;
        default: idCode = 16'h0000;
      endcase
      slot = '0;
      for (int m = 0; m < DATA_BYTES; m++) begin
        // R9: byte position inside the owning device
        slot = SEL_W'(m) & devMask;
        if (strobe.idMode) begin
          if (slot == SEL_W'(0))      laneByte[k][m] = idCode[7:0];
          else if (slot == SEL_W'(1)) laneByte[k][m] = idCode[15:8];
          else                        laneByte[k][m] = 8'h00;
        end else if (strobe.wideX8) begin
          // R7: byte repeated across the native width
          laneByte[k][m] = tblVal;
        end else begin
          laneByte[k][m] = (slot == '0) ? tblVal : 8'h00;
        end
      end
    end
  end

  // R10, R11: pack lanes into the word, clear bytes beyond the access
  always_comb begin
    logic [SEL_W-1:0] laneSel;
    logic [SEL_W-1:0] byteSel;
    nextData = '0;
    for (int b = 0; b < DATA_BYTES; b++) begin
      laneSel = SEL_W'(b >> bankLog);
      byteSel = SEL_W'(b) & bankMask;
      if (strobe.geomOk && ((SEL_W+1)'(b) < accBytes))
        nextData[8*b +: 8] = laneByte[laneSel][byteSel];
    end
  end

  // R1, R2: single capture register at the read port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobe.load;
      if (strobe.load) rdData <= nextData;
    end
  end

  function automatic logic sameBytes(input logic [DATA_W-1:0] d,
                                     input logic [LOG_W-1:0] aLog);
    logic ok;
    ok = 1'b1;
    for (int b = 1; b < DATA_BYTES; b++)
      if ((b < (1 << aLog)) && (d[8*b +: 8] != d[7:0])) ok = 1'b0;
    return ok;
  endfunction

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.load |=> $stable(rdData));

  // R11
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load |=> ((rdData >> (8 << $past(accLog))) == '0));

  // R8
  bad_geom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load && !strobe.geomOk |=> (rdData == '0));

  // R7
  x8_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load && !strobe.idMode && strobe.wideX8 && strobe.geomOk && (accLog == bankLog)
    |=> sameBytes(rdData, $past(accLog)));

endmodule

// File: rtl/cfi_query_responder.sv
module cfi_query_responder
  import cfi_qry_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          DATA_BYTES  = 4,
  parameter int          SECTOR_LOG  = 17,
  parameter int          BLOCK_LOG   = 6,
  parameter logic [15:0] MANUF_CODE  = 16'h0089,
  parameter logic [15:0] DEVICE_CODE = 16'h0018,
  localparam int         MAX_LOG     = $clog2(DATA_BYTES),
  localparam int         LOG_W       = $clog2(MAX_LOG + 2),
  localparam int         IDX_W       = ADDR_W + $clog2(DATA_BYTES * DATA_BYTES) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rdEn,
  input  logic                    idMode,
  input  logic [ADDR_W-1:0]       offset,
  input  logic [LOG_W-1:0]        accLog,
  input  logic [LOG_W-1:0]        bankLog,
  input  logic [LOG_W-1:0]        devLog,
  input  logic [LOG_W-1:0]        maxLog,
  output logic [8*DATA_BYTES-1:0] rdData,
  output logic                    rdValid
);

  qryStrobe_t                       strobe;
  logic [DATA_BYTES-1:0][IDX_W-1:0] laneIdx;

  cfi_qry_ctrl #(
    .ADDR_W (ADDR_W),
    .LANES  (DATA_BYTES),
    .IDX_W  (IDX_W),
    .LOG_W  (LOG_W),
    .MAX_LOG(MAX_LOG)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .rdEn   (rdEn),
    .idMode (idMode),
    .offset (offset),
    .accLog (accLog),
    .bankLog(bankLog),
    .devLog (devLog),
    .maxLog (maxLog),
    .strobe (strobe),
    .laneIdx(laneIdx)
  );

  cfi_qry_datapath #(
    .DATA_BYTES (DATA_BYTES),
    .IDX_W      (IDX_W),
    .LOG_W      (LOG_W),
    .SECTOR_LOG (SECTOR_LOG),
    .BLOCK_LOG  (BLOCK_LOG),
    .MANUF_CODE (MANUF_CODE),
    .DEVICE_CODE(DEVICE_CODE)
  ) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .laneIdx(laneIdx),
    .accLog (accLog),
    .bankLog(bankLog),
    .devLog (devLog),
    .rdData (rdData),
    .rdValid(rdValid)
  );

endmodule

// File: tb/test_cfi_query_responder.sv
module test_cfi_query_responder;

  localparam int SEC_LOG = 17;
  localparam int BLK_LOG = 6;
  localparam int MANUF   = 'h0089;
  localparam int DEVICE  = 'h0018;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rdEn = 1'b0;
  logic        idMode = 1'b0;
  logic [15:0] offset = '0;
  logic [1:0]  accLog = '0, bankLog = '0, devLog = '0, maxLog = '0;
  logic [31:0] rdData;
  logic        rdValid;

  int checks = 0;
  int errors = 0;
  logic [31:0] expData = '0;

  always #2 clk = ~clk;

  cfi_query_responder i_cfi_query_responder (
    .clk(clk), .rst_n(rst_n), .rdEn(rdEn), .idMode(idMode), .offset(offset),
    .accLog(accLog), .bankLog(bankLog), .devLog(devLog), .maxLog(maxLog),
    .rdData(rdData), .rdValid(rdValid)
  );

  function automatic int lg(input int v);
    int r = 0;
    while ((1 << r) < v) r++;
    return r;
  endfunction

  function automatic int refTable(input int idx, input int bank, input int devs);
    int perDev = 64 / devs - 1;
    case (idx)
      'h10: return 'h51;  'h11: return 'h52;  'h12: return 'h59;
      'h13: return 'h01;  'h15: return 'h31;
      'h27: return SEC_LOG + BLK_LOG - lg(devs);
      'h2A: return (bank == 1) ? 'h08 : 'h0B;
      'h2C: return 1;
      'h2D: return perDev & 255;
      'h2E: return (perDev >> 8) & 255;
      'h2F: return ((1 << SEC_LOG) >> 8) & 255;
      'h30: return ((1 << SEC_LOG) >> 16) & 255;
      'h31: return 'h50;  'h32: return 'h52;  'h33: return 'h49;
      'h34: return 'h31;  'h35: return 'h30;
      default: return 0;
    endcase
  endfunction

  // Behavioural reference, one byte at a time
  function automatic logic [31:0] refRead(input bit id, input int off,
      input int aL, input int bL, input int dL, input int mL);
    logic [31:0] res = '0;
    int acc, bank, dev, mx, sh;
    if (aL > 2 || bL > 2 || dL > 2 || mL > 2) return '0;
    acc = 1 << aL; bank = 1 << bL; dev = 1 << dL; mx = 1 << mL;
    if (dev > bank || dev > mx || (mx != dev && dev != 1)) return '0;
    sh = bL + mL - dL;
    for (int b = 0; b < acc; b++) begin
      int lane = b / bank;
      int j = (b % bank) % dev;
      int idx = (off + lane * bank) >> sh;
      int val;
      if (id) begin
        int code = ((idx % 256) == 0) ? MANUF : ((idx % 256) == 1) ? DEVICE : 0;
        val = (j < 2) ? ((code >> (8 * j)) & 255) : 0;
      end else begin
        int t = (idx > 'h52) ? 0 : refTable(idx, bank, bank / dev);
        val = (mx != dev) ? t : ((j == 0) ? t : 0);
      end
      res[8*b +: 8] = 8'(val);
    end
    return res;
  endfunction

  task automatic check(input string tag, input bit expValid);
    checks++;
    if (rdData !== expData || rdValid !== expValid) begin
      errors++;
      $display("FAIL %s: rdData=%h rdValid=%b expected rdData=%h rdValid=%b",
               tag, rdData, rdValid, expData, expValid);
    end
  endtask

  // Drive at the falling edge, compare one time unit after the next rising edge
  task automatic step(input string tag, input bit en, input bit id, input int off,
                      input int aL, input int bL, input int dL, input int mL);
    rdEn = en; idMode = id; offset = 16'(off);
    accLog = 2'(aL); bankLog = 2'(bL); devLog = 2'(dL); maxLog = 2'(mL);
    if (en) expData = refRead(id, off, aL, bL, dL, mL);
    @(posedge clk);
    #1;
    check(tag, en);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1; check("R1", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    step("R1", 0, 0, 'h10, 0, 0, 0, 0);

    // R5: text entries, one-byte bank
    step("R5", 1, 0, 'h10, 0, 0, 0, 0);
    step("R5", 1, 0, 'h11, 0, 0, 0, 0);
    step("R5", 1, 0, 'h12, 0, 0, 0, 0);
    step("R5", 1, 0, 'h13, 0, 0, 0, 0);
    step("R5", 1, 0, 'h15, 0, 0, 0, 0);
    for (int i = 'h31; i <= 'h35; i++) step("R5", 1, 0, i, 0, 0, 0, 0);
    step("R5", 1, 0, 'h14, 0, 0, 0, 0);
    // R2: idle cycles hold the last word
    step("R2", 0, 0, 'h11, 0, 0, 0, 0);
    step("R2", 0, 1, 'h00, 2, 2, 2, 2);
    // R3: scaling for a 16-bit bank
    step("R3", 1, 0, 'h20, 1, 1, 1, 1);
    step("R3", 1, 0, 'h22, 1, 1, 1, 1);
    // R9: two x16 devices on a 32-bit bank
    step("R9", 1, 0, 'h40, 2, 2, 1, 1);
    step("R9", 1, 0, 'h44, 2, 2, 1, 1);
    // R7: x16 parts in byte mode, 32-bit bank
    step("R7", 1, 0, 'h80, 2, 2, 0, 1);
    step("R7", 1, 0, 'h88, 2, 2, 0, 1);
    // R10: wide access over narrow banks
    step("R10", 1, 0, 'h20, 2, 0, 0, 1);
    step("R10", 1, 0, 'h20, 2, 1, 1, 1);
    step("R10", 1, 0, 'h62, 2, 1, 1, 1);
    // R11: access narrower than the bank
    step("R11", 1, 0, 'h40, 0, 2, 1, 1);
    step("R11", 1, 0, 'h40, 1, 2, 0, 0);
    // R4: index above the table must not alias
    step("R4", 1, 0, 'h110, 0, 0, 0, 0);
    step("R4", 1, 0, 'h52, 0, 0, 0, 0);
    step("R4", 1, 0, 'h4420, 1, 1, 1, 1);
    // R6: geometry entries for several device counts
    for (int i = 'h27; i <= 'h30; i++) begin
      step("R6", 1, 0, i, 0, 0, 0, 0);
      step("R6", 1, 0, i * 4, 2, 2, 0, 0);
      step("R6", 1, 0, i * 4, 2, 2, 1, 1);
    end
    // R8: unsupported geometry reads zero
    step("R8", 1, 0, 'h40, 2, 2, 1, 2);
    step("R8", 1, 0, 'h10, 0, 0, 1, 1);
    step("R8", 1, 0, 'h10, 0, 3, 0, 0);
    step("R8", 1, 1, 'h00, 3, 0, 0, 0);
    step("R8", 1, 0, 'h10, 0, 0, 0, 3);
    // R12: identifier mode
    step("R12", 1, 1, 'h00, 0, 0, 0, 0);
    step("R12", 1, 1, 'h01, 0, 0, 0, 0);
    step("R12", 1, 1, 'h02, 0, 0, 0, 0);
    step("R12", 1, 1, 'h100, 0, 0, 0, 0);
    step("R12", 1, 1, 'h02, 1, 1, 1, 1);
    step("R12", 1, 1, 'h00, 2, 2, 1, 1);
    step("R12", 1, 1, 'h00, 2, 2, 2, 2);
    step("R12", 1, 1, 'h04, 2, 2, 0, 1);
    step("R12", 1, 1, 'h00, 2, 0, 0, 0);

    // Mixed sweep over settings, offsets and idle gaps
    for (int n = 0; n < 600; n++) begin
      int aL = $urandom_range(0, 2);
      int bL = $urandom_range(0, 2);
      int mL = $urandom_range(0, 2);
      int dL = $urandom_range(0, 2);
      int off = $urandom_range(0, 'h1ff);
      bit en = ($urandom_range(0, 3) != 0);
      bit id = ($urandom_range(0, 3) == 0);
      step(id ? "R12" : "R10", en, id, off, aL, bL, dL, mL);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule